// File: doc/BRIEF.md
# Interrupt Bid Arbiter with Threshold

This block decides which of eighteen interrupt sources of a four-channel serial controller is served next. The sources are four receive-data sources, four receive-break sources, four transmit-space sources, four change-of-state sources and two counter/timer sources. Each source that is enabled and active forms an 8-bit bid. The bid's top three bits hold a fill level or a programmable priority. The middle three bits are a fixed type code, and the low two bits are a fixed channel number. Because the type and channel parts are unique, no two bids can ever be equal, and no bid can be zero.

Once per arbitration period an evaluation strobe latches the numerically largest bid. That latched winner is offered inverted on an active-low bus, so FFh means that nothing bids. The winner is also compared with a programmable threshold, and the active-low interrupt request is driven from that comparison. When the host acknowledges, a falling edge on the acknowledge input copies the latched winner into the current-interrupt register. A small state machine keeps this copy consistent with the evaluation strobe.

The state machine has two states. ACK_IDLE lets each strobe update the winner latch. ACK_HOLD swallows the next strobe. The transitions are:
- ACK_IDLE to ACK_HOLD, taken on an acknowledge fall with no strobe in that cycle.
- ACK_HOLD to ACK_IDLE, taken on the next strobe, which is suppressed.
- ACK_IDLE to ACK_IDLE, taken in every other case, including an acknowledge fall that coincides with a strobe.

Top module: `irq_bid_arbiter`

## Requirements
- R1: A receive source bids {min(count,7), err, 2'b11, ch} with ch = 0..3. Here count is its nibble of rx_count at bits [4*ch+3:4*ch], and err is rx_err[ch]. A count of zero makes no bid.
- R2: A transmit source bids {1'b0, min(free,3), 3'b010, ch}. Here free is its nibble of tx_free. A free count of zero (FIFO full) makes no bid, so an empty transmit FIFO (0x68 on channel 0) ranks below a receive FIFO holding four bytes (0x8C).
- R3: A break source bids {p, 3'b100, ch} and a change-of-state source bids {p, 3'b001, ch}. A counter/timer bids {p, 3'b101, c}, with c = 01 for timer 0 and c = 11 for timer 1. Each bids only while its flag is set.
  - The 3-bit value p is taken from prio_cfg[3*i+2:3*i]. Index i runs 0..3 for break, 4..7 for change-of-state and 8..9 for the timers.
  - The flags are brk_flag[ch], cos_flag[ch] and ct_flag[k].
- R4: bid_mask bit j enables source j. Bits 3:0 are receive, 7:4 are break, 11:8 are transmit, 15:12 are change-of-state and 17:16 are the timers. A masked source contributes nothing.
- R5: On each accepted strobe the largest bid is latched. Between accepted strobes the latched winner, and so bus_n, does not change.
- R6: When no source bids, the latched winner is 0, bus_n reads FFh and irq_n is high.
- R7: irq_n is low exactly when the latched winner is strictly greater than threshold. A change of threshold takes effect without waiting for a strobe.
- R8: An acknowledge fall that coincides with a strobe loads cir with the winner latched before that strobe, while the strobe still updates the latch. Without an acknowledge fall, cir holds its value.
- R9: An acknowledge fall without a strobe loads cir with the latched winner. The next strobe is then suppressed, and the strobe after it updates the latch again.
- R10: During reset, bus_n is FFh, irq_n is 1 and cir is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_stb | input | 1 | One-cycle strobe per arbitration period |
| ack_n | input | 1 | Active-low interrupt acknowledge |
| rx_count | input | 16 | Receive FIFO byte counts, one nibble per channel |
| rx_err | input | 4 | Receive error flag per channel |
| tx_free | input | 16 | Transmit FIFO free byte counts, one nibble per channel |
| brk_flag | input | 4 | Break seen, per channel |
| cos_flag | input | 4 | Change of state seen, per channel |
| ct_flag | input | 2 | Counter/timer event, per timer |
| bid_mask | input | 18 | Per-source bid enable |
| prio_cfg | input | 30 | Programmable 3-bit priorities |
| threshold | input | 8 | Interrupt threshold |
| irq_n | output | 1 | Active-low interrupt request |
| bus_n | output | 8 | Inverted latched winner |
| cir | output | 8 | Current-interrupt register |

## Verification
The two functions that can coincide are the winner update on an evaluation strobe and the capture on an acknowledge fall. The bench drives ack_n low in exactly the cycle eval_stb is high, with inputs that change the winner. It then expects cir to hold the old winner and bus_n to show the new one. A second case drops ack_n between strobes, then changes the inputs. It expects the first strobe after that fall to leave bus_n untouched and the following strobe to update it.

// File: rtl/irq_bid_pkg.sv
package irq_bid_pkg;
    localparam int BID_W = 8;
    localparam int LVL_W = 3;
    localparam int TY_W  = 3;

    typedef enum logic [2:0] {SK_RX, SK_TX, SK_BRK, SK_COS, SK_CT} src_kind_e;
    typedef enum logic [0:0] {ACK_IDLE, ACK_HOLD} ack_state_e;

    function automatic logic [TY_W-1:0] type_code(src_kind_e kind, logic err);
        case (kind)
            SK_RX:   return {err, 2'b11};
            SK_TX:   return 3'b010;
            SK_BRK:  return 3'b100;
            SK_COS:  return 3'b001;
            default: return 3'b101;
        endcase
    endfunction
endpackage

// File: rtl/irq_bid_former.sv
module irq_bid_former
    import irq_bid_pkg::*;
#(
    parameter src_kind_e KIND = SK_RX,
    parameter int        CHAN = 0
) (
    input  logic             en,
    input  logic             active,
    input  logic [LVL_W-1:0] level,
    input  logic             err,
    output logic [BID_W-1:0] bid
);
    localparam logic [1:0] CH_CODE = CHAN[1:0];

    always_comb begin
        bid = (en && active) ? {level, type_code(KIND, err), CH_CODE} : '0;
    end
endmodule

// File: rtl/irq_bid_max.sv
module irq_bid_max
    import irq_bid_pkg::*;
#(
    parameter int N = 18
) (
    input  logic [BID_W-1:0] bids [N],
    output logic [BID_W-1:0] top_bid
);
    always_comb begin
        top_bid = '0;
        for (int i = 0; i < N; i++) begin
            if (bids[i] > top_bid) top_bid = bids[i];
        end
    end
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
    import irq_bid_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eval_stb,
    input  logic             ack_n,
    input  logic [BID_W-1:0] win,
    output logic             eval_ok,
    output logic [BID_W-1:0] cir
);
    ack_state_e state, state_nx;
    logic       ack_q;
    logic       ack_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_q <= 1'b1;
        else        ack_q <= ack_n;
    end

    assign ack_fall = ack_q & ~ack_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ACK_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        eval_ok  = 1'b0;
        unique case (state)
            ACK_IDLE: begin
                eval_ok = eval_stb;
                if (ack_fall && !eval_stb) state_nx = ACK_HOLD;
            end
            ACK_HOLD: begin
                if (eval_stb) state_nx = ACK_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cir <= '0;
        else if (ack_fall) cir <= win;
    end
endmodule

// File: rtl/irq_bid_arbiter.sv
module irq_bid_arbiter
    import irq_bid_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int N_CT   = 2,
    parameter int CNT_W  = 4,
    parameter int PRIO_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       eval_stb,
    input  logic                       ack_n,
    input  logic [N_CH*CNT_W-1:0]      rx_count,
    input  logic [N_CH-1:0]            rx_err,
    input  logic [N_CH*CNT_W-1:0]      tx_free,
    input  logic [N_CH-1:0]            brk_flag,
    input  logic [N_CH-1:0]            cos_flag,
    input  logic [N_CT-1:0]            ct_flag,
    input  logic [4*N_CH+N_CT-1:0]     bid_mask,
    input  logic [(2*N_CH+N_CT)*PRIO_W-1:0] prio_cfg,
    input  logic [BID_W-1:0]           threshold,
    output logic                       irq_n,
    output logic [BID_W-1:0]           bus_n,
    output logic [BID_W-1:0]           cir
);
    localparam int N_SRC  = 4*N_CH + N_CT;
    localparam int RX_MAX = 7;
    localparam int TX_MAX = 3;

    logic [BID_W-1:0] bids [N_SRC];
    logic [BID_W-1:0] top_bid;
    logic [BID_W-1:0] win_q;
    logic             eval_ok;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [CNT_W-1:0] rxc, txc;
        logic [LVL_W-1:0] rx_lvl, tx_lvl;
        assign rxc    = rx_count[CNT_W*c +: CNT_W];
        assign txc    = tx_free[CNT_W*c +: CNT_W];
        assign rx_lvl = (rxc > CNT_W'(RX_MAX)) ? LVL_W'(RX_MAX) : rxc[LVL_W-1:0];
        assign tx_lvl = (txc > CNT_W'(TX_MAX)) ? LVL_W'(TX_MAX) : {1'b0, txc[LVL_W-2:0]};

        irq_bid_former #(.KIND(SK_RX), .CHAN(c)) u_rx (
            .en(bid_mask[c]), .active(rxc != '0), .level(rx_lvl),
            .err(rx_err[c]), .bid(bids[c]));
        irq_bid_former #(.KIND(SK_BRK), .CHAN(c)) u_brk (
            .en(bid_mask[N_CH+c]), .active(brk_flag[c]),
            .level(prio_cfg[PRIO_W*c +: PRIO_W]), .err(1'b0), .bid(bids[N_CH+c]));
        irq_bid_former #(.KIND(SK_TX), .CHAN(c)) u_tx (
            .en(bid_mask[2*N_CH+c]), .active(txc != '0), .level(tx_lvl),
            .err(1'b0), .bid(bids[2*N_CH+c]));
        irq_bid_former #(.KIND(SK_COS), .CHAN(c)) u_cos (
            .en(bid_mask[3*N_CH+c]), .active(cos_flag[c]),
            .level(prio_cfg[PRIO_W*(N_CH+c) +: PRIO_W]), .err(1'b0),
            .bid(bids[3*N_CH+c]));
    end

    for (genvar k = 0; k < N_CT; k++) begin : g_ct
        irq_bid_former #(.KIND(SK_CT), .CHAN(2*k+1)) u_ct (
            .en(bid_mask[4*N_CH+k]), .active(ct_flag[k]),
            .level(prio_cfg[PRIO_W*(2*N_CH+k) +: PRIO_W]), .err(1'b0),
            .bid(bids[4*N_CH+k]));
    end

    irq_bid_max #(.N(N_SRC)) u_max (.bids(bids), .top_bid(top_bid));

    irq_ack_ctrl u_ack (
        .clk(clk), .rst_n(rst_n), .eval_stb(eval_stb), .ack_n(ack_n),
        .win(win_q), .eval_ok(eval_ok), .cir(cir));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       win_q <= '0;
        else if (eval_ok) win_q <= top_bid;
    end

    assign bus_n = ~win_q;
    assign irq_n = !(win_q > threshold);
endmodule

// File: rtl/irq_bid_arbiter_chk.sv
module irq_bid_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       eval_stb,
    input logic       ack_n,
    input logic [7:0] threshold,
    input logic       irq_n,
    input logic [7:0] bus_n,
    input logic [7:0] cir
);
    logic ack_seen;
    logic fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_seen <= 1'b1;
        else        ack_seen <= ack_n;
    end
    assign fall = ack_seen && !ack_n;

    p_bus_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_stb |=> $stable(bus_n));

    p_idle_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_n == 8'hFF) |-> irq_n);

    p_thr_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == !((~bus_n) > threshold));

    p_cir_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(cir));

    p_cir_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> (cir == ~$past(bus_n)));
endmodule

bind irq_bid_arbiter irq_bid_arbiter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .eval_stb(eval_stb), .ack_n(ack_n),
    .threshold(threshold), .irq_n(irq_n), .bus_n(bus_n), .cir(cir));

// File: tb/irq_bid_arbiter_test.sv
module irq_bid_arbiter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eval_stb = 1'b0;
    logic        ack_n = 1'b1;
    logic [15:0] rx_count = '0;
    logic [3:0]  rx_err = '0;
    logic [15:0] tx_free = '0;
    logic [3:0]  brk_flag = '0;
    logic [3:0]  cos_flag = '0;
    logic [1:0]  ct_flag = '0;
    logic [17:0] bid_mask = '0;
    logic [29:0] prio_cfg = '0;
    logic [7:0]  threshold = '0;
    logic        irq_n;
    logic [7:0]  bus_n;
    logic [7:0]  cir;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    irq_bid_arbiter uut (.*);

    typedef struct packed {
        logic [15:0] rxc;
        logic [3:0]  rxe;
        logic [15:0] txf;
        logic [3:0]  brk;
        logic [3:0]  cos;
        logic [1:0]  ct;
        logic [17:0] msk;
        logic [29:0] pri;
        logic [7:0]  thr;
        logic [7:0]  exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{16'h0000, 4'h0, 16'h0000, 4'h0, 4'h0, 2'b00, 18'h3FFFF, 30'd0, 8'h00, 8'h00}, // R6
        '{16'h0001, 4'h0, 16'h0000, 4'h0, 4'h0, 2'b00, 18'h3FFFF, 30'd0, 8'h00, 8'h2C}, // R1
        '{16'h0801, 4'h4, 16'h0000, 4'h0, 4'h0, 2'b00, 18'h3FFFF, 30'd0, 8'hFE, 8'hFE}, // R1 R7
        '{16'h0000, 4'h0, 16'h8001, 4'h0, 4'h0, 2'b00, 18'h3FFFF, 30'd0, 8'h6A, 8'h6B}, // R2
        '{16'h0000, 4'h0, 16'h0000, 4'h2, 4'h0, 2'b00, 18'h3FFFF, 30'd0, 8'h00, 8'h11}, // R2 R3
        '{16'h0004, 4'h0, 16'h0008, 4'h0, 4'h0, 2'b00, 18'h3FFFF, 30'd0, 8'h00, 8'h8C}, // R2
        '{16'h0000, 4'h0, 16'h0000, 4'h1, 4'h0, 2'b10, 18'h3FFFF,
          (30'd7 << 27) | 30'd7, 8'h00, 8'hF7},                                       // R3
        '{16'h0820, 4'h4, 16'h0000, 4'h0, 4'h0, 2'b00, 18'h3FFFB, 30'd0, 8'h00, 8'h4D}, // R4
        '{16'h0820, 4'h0, 16'h0000, 4'h0, 4'h0, 2'b00, 18'h00000, 30'd0, 8'h00, 8'h00}, // R4 R6
        '{16'h0000, 4'h0, 16'h0000, 4'h0, 4'h4, 2'b01, 18'h3FFFF, 30'd0, 8'h00, 8'h15}, // R3
        '{16'h0000, 4'h0, 16'h0030, 4'h0, 4'h8, 2'b00, 18'h3FFFF,
          30'd5 << 21, 8'hA6, 8'hA7}                                                  // R3 R7
    };

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        rx_count = v.rxc; rx_err = v.rxe; tx_free = v.txf;
        brk_flag = v.brk; cos_flag = v.cos; ct_flag = v.ct;
        bid_mask = v.msk; prio_cfg = v.pri; threshold = v.thr;
    endtask

    task automatic pulse_eval();
        eval_stb = 1'b1;
        @(negedge clk);
        eval_stb = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk8("R10 bus_n", bus_n, 8'hFF);
        chk1("R10 irq_n", irq_n, 1'b1);
        chk8("R10 cir", cir, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            @(negedge clk);
            pulse_eval();
            chk8($sformatf("R5 vector %0d bus_n", i), bus_n, ~VEC[i].exp);
            chk1($sformatf("R7 vector %0d irq_n", i), irq_n, !(VEC[i].exp > VEC[i].thr));
        end

        // R5: inputs change with no strobe, latched winner stays 0xA7
        rx_count = 16'h0008; threshold = 8'h00;
        repeat (3) @(negedge clk);
        chk8("R5 no strobe", bus_n, ~8'hA7);

        // R8: acknowledge fall coincides with strobe
        apply(VEC[1]);
        eval_stb = 1'b1; ack_n = 1'b0;
        @(negedge clk);
        eval_stb = 1'b0;
        chk8("R8 cir old winner", cir, 8'hA7);
        chk8("R8 latch updated", bus_n, ~8'h2C);
        ack_n = 1'b1;
        repeat (2) @(negedge clk);
        chk8("R8 cir held", cir, 8'hA7);

        // R9: acknowledge fall between strobes
        ack_n = 1'b0;
        @(negedge clk);
        chk8("R9 cir load", cir, 8'h2C);
        rx_count = 16'h0004;
        @(negedge clk);
        pulse_eval();
        chk8("R9 strobe suppressed", bus_n, ~8'h2C);
        pulse_eval();
        chk8("R9 next strobe updates", bus_n, ~8'h8C);
        ack_n = 1'b1;

        // R7: threshold acts at once
        threshold = 8'h8B;
        #1;
        chk1("R7 below winner", irq_n, 1'b0);
        threshold = 8'h8C;
        #1;
        chk1("R7 equal winner", irq_n, 1'b1);
        @(negedge clk);
        chk8("R8 cir unchanged", cir, 8'h2C);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule